// File: doc/BRIEF.md
# Bayer optical-black region statistics

This block watches a raw Bayer pixel stream and totals the optical-black pixels that fall inside a programmable rectangle. The stream carries one pixel per clock with a valid qualifier, a start-of-frame marker on the first pixel of a frame and an end-of-line marker on the last pixel of each line. Each pixel inside the rectangle is added into one of four saturating totals. The total is picked by the pixel's place in the 2x2 colour mosaic and by a two-bit phase setting. The block also forms an 8-bit checksum of the sampled frame. The pixel stream is forwarded to the output unchanged and without delay.

Rectangle and phase settings are staged. A commit strobe captures the setting inputs and raises a pending flag. The captured set takes effect at the next start-of-frame, and that start-of-frame pixel is already classified with the new set. Results are gathered through a freeze handshake run by a four-state machine. The states are IDLE, ARMED, GATHER and HOLD. IDLE goes to ARMED when the request is high. ARMED goes to GATHER on a start-of-frame, which clears the totals. GATHER goes to HOLD on the next start-of-frame, which publishes the results and raises the frozen flag. HOLD goes back to IDLE once the request has returned low. In every other case the state stays where it is. A waiting commit does not hold up any of these transitions.

Top module: `bayer_black_stats`

## Requirements
- R1: m_valid, m_data, m_sof and m_eol equal s_valid, s_data, s_sof and s_eol in the same cycle.
- R2: Pixel coordinates count from 0. A valid pixel with s_sof is at column 0, line 0. The pixel after an s_eol pixel starts column 0 of the next line. A pixel is inside horizontally when roi_h_first <= column < roi_h_limit.
- R3: A line is inside when (roi_v_before + 1) mod 65536 <= line <= roi_v_last. So roi_v_before = 65535 makes line 0 the first included line.
- R4: With phase p = cfa_phase, an included pixel on line y, column x is added to total number {y[0] ^ p[1], x[0] ^ p[0]}. For example, phase 0 gives line 0 channels 0,1 and line 1 channels 2,3.
- R5: cfg_commit captures the setting inputs, and stat_pending reads 1 from the next cycle. At the next valid start-of-frame the captured set governs that pixel and the rest of the frame, and stat_pending returns to 0.
- R6: A freeze request is acted on while a commit is still pending.
- R7: From IDLE, a high freeze_req clears stat_frozen in the next cycle. The next valid start-of-frame clears the totals and counts its own pixel, and stat_running reads 1 while gathering. The following start-of-frame ends the round: stat_running drops and stat_frozen rises. That pixel is not counted.
- R8: While stat_frozen is 1, the totals and frame_csum do not change. A new round starts only after freeze_req has been seen low in HOLD.
- R9: frame_csum is the sum modulo 256 of every pixel value of the sampled frame, published when the round ends.
- R10: Each total is ACC_W bits wide (32 by default) and stays at its maximum value instead of wrapping.
- R11: After reset the status bits, the totals and frame_csum are 0. The active rectangle is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pixel valid |
| s_data | input | PIX_W | Input pixel value |
| s_sof | input | 1 | First pixel of a frame |
| s_eol | input | 1 | Last pixel of a line |
| m_valid | output | 1 | Forwarded valid |
| m_data | output | PIX_W | Forwarded pixel |
| m_sof | output | 1 | Forwarded start-of-frame |
| m_eol | output | 1 | Forwarded end-of-line |
| roi_h_first | input | 16 | First included column |
| roi_h_limit | input | 16 | Column just past the last included one |
| roi_v_before | input | 16 | Line before the first included line (wraps) |
| roi_v_last | input | 16 | Last included line |
| cfa_phase | input | 2 | Mosaic phase |
| cfg_commit | input | 1 | Capture the setting inputs |
| freeze_req | input | 1 | Freeze request level |
| stat_running | output | 1 | A round is gathering |
| stat_pending | output | 1 | A captured setting awaits a frame start |
| stat_frozen | output | 1 | Results are complete and held |
| frame_csum | output | 8 | Checksum of the sampled frame |
| sum_ch0 | output | ACC_W | Total for channel 0 |
| sum_ch1 | output | ACC_W | Total for channel 1 |
| sum_ch2 | output | ACC_W | Total for channel 2 |
| sum_ch3 | output | ACC_W | Total for channel 3 |

## Verification
The assertions assume that software keeps freeze_req high from its rise until stat_frozen is seen. They also assume it drops the request before asking again, so a rising request is only ever seen in IDLE. They further assume that a start-of-frame is only meaningful with valid high. The stimulus follows this discipline. It changes freeze_req only in IDLE, or in HOLD after the results are out, and raises s_sof only on the first valid pixel of a frame. Idle gaps and commits in the middle of a frame are still placed inside the stream.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    localparam int COORD_W = 16;

    typedef struct packed {
        logic [COORD_W-1:0] h_first;
        logic [COORD_W-1:0] h_limit;
        logic [COORD_W-1:0] v_before;
        logic [COORD_W-1:0] v_last;
        logic [1:0]         phase;
    } roi_cfg_t;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_ARMED  = 2'd1,
        FS_GATHER = 2'd2,
        FS_HOLD   = 2'd3
    } freeze_state_t;

    localparam roi_cfg_t ROI_RESET = '{
        h_first:  '0,
        h_limit:  '0,
        v_before: '1,
        v_last:   '0,
        phase:    2'b00
    };

    function automatic logic [1:0] mosaic_channel(input logic [1:0] phase,
                                                  input logic       line_odd,
                                                  input logic       col_odd);
        return {line_odd ^ phase[1], col_odd ^ phase[0]};
    endfunction

endpackage

// File: rtl/bbs_cfg_shadow.sv
module bbs_cfg_shadow
    import bbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  roi_cfg_t cfg_in,
    input  logic     frame_start,
    output roi_cfg_t cfg_eff,
    output logic     pending
);

    roi_cfg_t staged_q;
    roi_cfg_t active_q;
    logic     pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q  <= ROI_RESET;
            active_q  <= ROI_RESET;
            pending_q <= 1'b0;
        end else begin
            if (frame_start && pending_q) begin
                active_q <= staged_q;
            end
            if (commit) begin
                staged_q  <= cfg_in;
                pending_q <= 1'b1;
            end else if (frame_start) begin
                pending_q <= 1'b0;
            end
        end
    end

    // the frame-start pixel already uses a waiting set
    assign cfg_eff = (frame_start && pending_q) ? staged_q : active_q;
    assign pending = pending_q;

endmodule

// File: rtl/bbs_raster_pos.sv
module bbs_raster_pos #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px_valid,
    input  logic          px_sof,
    input  logic          px_eol,
    output logic [CW-1:0] col,
    output logic [CW-1:0] line
);

    logic [CW-1:0] next_col_q;
    logic [CW-1:0] next_line_q;

    assign col  = px_sof ? '0 : next_col_q;
    assign line = px_sof ? '0 : next_line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_col_q  <= '0;
            next_line_q <= '0;
        end else if (px_valid) begin
            if (px_eol) begin
                next_col_q  <= '0;
                next_line_q <= line + 1'b1;
            end else begin
                next_col_q  <= col + 1'b1;
                next_line_q <= line;
            end
        end
    end

endmodule

// File: rtl/bbs_sat_accum.sv
module bbs_sat_accum #(
    parameter int PIX_W = 12,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [PIX_W-1:0] add_val,
    output logic [ACC_W-1:0] total
);

    localparam int EXT_W = ACC_W + 1 - PIX_W;

    logic [ACC_W-1:0] total_q;
    logic [ACC_W:0]   wide_sum;
    logic [ACC_W-1:0] sat_sum;

    assign wide_sum = {1'b0, total_q} + {{EXT_W{1'b0}}, add_val};
    assign sat_sum  = wide_sum[ACC_W] ? {ACC_W{1'b1}} : wide_sum[ACC_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clear) begin
            total_q <= add_en ? {{(ACC_W-PIX_W){1'b0}}, add_val} : '0;
        end else if (add_en) begin
            total_q <= sat_sum;
        end
    end

    assign total = total_q;

endmodule

// File: rtl/bayer_black_stats.sv
module bayer_black_stats
    import bbs_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int ACC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic [PIX_W-1:0]     s_data,
    input  logic                 s_sof,
    input  logic                 s_eol,
    output logic                 m_valid,
    output logic [PIX_W-1:0]     m_data,
    output logic                 m_sof,
    output logic                 m_eol,
    input  logic [COORD_W-1:0]   roi_h_first,
    input  logic [COORD_W-1:0]   roi_h_limit,
    input  logic [COORD_W-1:0]   roi_v_before,
    input  logic [COORD_W-1:0]   roi_v_last,
    input  logic [1:0]           cfa_phase,
    input  logic                 cfg_commit,
    input  logic                 freeze_req,
    output logic                 stat_running,
    output logic                 stat_pending,
    output logic                 stat_frozen,
    output logic [7:0]           frame_csum,
    output logic [ACC_W-1:0]     sum_ch0,
    output logic [ACC_W-1:0]     sum_ch1,
    output logic [ACC_W-1:0]     sum_ch2,
    output logic [ACC_W-1:0]     sum_ch3
);

    localparam int NUM_CH = 4;

    // pass-through
    assign m_valid = s_valid;
    assign m_data  = s_data;
    assign m_sof   = s_sof;
    assign m_eol   = s_eol;

    logic pix_sof;
    assign pix_sof = s_valid && s_sof;

    // settings
    roi_cfg_t cfg_in;
    roi_cfg_t cfg_eff;

    assign cfg_in = '{
        h_first:  roi_h_first,
        h_limit:  roi_h_limit,
        v_before: roi_v_before,
        v_last:   roi_v_last,
        phase:    cfa_phase
    };

    bbs_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (cfg_commit),
        .cfg_in      (cfg_in),
        .frame_start (pix_sof),
        .cfg_eff     (cfg_eff),
        .pending     (stat_pending)
    );

    // position and region test
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] line;
    logic [COORD_W-1:0] v_first;
    logic               in_h;
    logic               in_v;
    logic               in_roi;
    logic [1:0]         chan;

    bbs_raster_pos #(.CW(COORD_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .px_valid (s_valid),
        .px_sof   (s_sof),
        .px_eol   (s_eol),
        .col      (col),
        .line     (line)
    );

    assign v_first = cfg_eff.v_before + 1'b1;
    assign in_h    = (col >= cfg_eff.h_first) && (col < cfg_eff.h_limit);
    assign in_v    = (line >= v_first) && (line <= cfg_eff.v_last);
    assign in_roi  = in_h && in_v;
    assign chan    = mosaic_channel(cfg_eff.phase, line[0], col[0]);

    // freeze state machine
    freeze_state_t state_q;
    freeze_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:   if (freeze_req) state_d = FS_ARMED;
            FS_ARMED:  if (pix_sof)    state_d = FS_GATHER;
            FS_GATHER: if (pix_sof)    state_d = FS_HOLD;
            FS_HOLD:   if (!freeze_req) state_d = FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    logic round_start;
    logic round_end;
    logic gather_pix;

    assign round_start = (state_q == FS_ARMED)  && pix_sof;
    assign round_end   = (state_q == FS_GATHER) && pix_sof;
    assign gather_pix  = (state_q == FS_GATHER) && s_valid && !s_sof;

    // checksum byte of the pixel
    logic [7:0] px_byte;
    generate
        if (PIX_W >= 8) begin : g_byte_trunc
            assign px_byte = s_data[7:0];
        end else begin : g_byte_ext
            assign px_byte = {{(8 - PIX_W){1'b0}}, s_data};
        end
    endgenerate

    // output process
    logic       frozen_q;
    logic [7:0] csum_run_q;
    logic [7:0] csum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen_q   <= 1'b0;
            csum_run_q <= '0;
            csum_q     <= '0;
        end else begin
            if (state_q == FS_IDLE && freeze_req) frozen_q <= 1'b0;
            else if (round_end)                   frozen_q <= 1'b1;

            if (round_start)     csum_run_q <= px_byte;
            else if (gather_pix) csum_run_q <= csum_run_q + px_byte;

            if (round_end) csum_q <= csum_run_q;
        end
    end

    assign stat_frozen  = frozen_q;
    assign stat_running = (state_q == FS_GATHER);
    assign frame_csum   = csum_q;

    // channel totals
    logic [ACC_W-1:0] totals [NUM_CH];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            bbs_sat_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_acc (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (round_start),
                .add_en  ((round_start || gather_pix) && in_roi && (chan == 2'(g))),
                .add_val (s_data),
                .total   (totals[g])
            );
        end
    endgenerate

    assign sum_ch0 = totals[0];
    assign sum_ch1 = totals[1];
    assign sum_ch2 = totals[2];
    assign sum_ch3 = totals[3];

endmodule

// File: rtl/bayer_black_stats_checker.sv
module bayer_black_stats_checker #(
    parameter int PIX_W = 12,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_sof,
    input logic [PIX_W-1:0] s_data,
    input logic [PIX_W-1:0] m_data,
    input logic             cfg_commit,
    input logic             freeze_req,
    input logic             stat_running,
    input logic             stat_pending,
    input logic             stat_frozen,
    input logic [7:0]       frame_csum,
    input logic [ACC_W-1:0] sum_ch0,
    input logic [ACC_W-1:0] sum_ch1,
    input logic [ACC_W-1:0] sum_ch2,
    input logic [ACC_W-1:0] sum_ch3
);

    always_comb begin
        AST_PASS_DATA: assert (m_data == s_data); // R1
    end

    AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_commit |=> stat_pending); // R5

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pending && s_valid && s_sof && !cfg_commit) |=> !stat_pending); // R5

    AST_REQ_UNFREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_req) |=> !stat_frozen); // R7

    AST_ROUND_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_running && s_valid && s_sof) |=> (stat_frozen && !stat_running)); // R7

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_running && stat_frozen)); // R7

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_frozen ##1 stat_frozen) |-> ($stable(sum_ch0) && $stable(sum_ch1) &&
                                           $stable(sum_ch2) && $stable(sum_ch3) &&
                                           $stable(frame_csum))); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_running && $past(stat_running)) |-> (sum_ch0 >= $past(sum_ch0) &&
                                                   sum_ch1 >= $past(sum_ch1) &&
                                                   sum_ch2 >= $past(sum_ch2) &&
                                                   sum_ch3 >= $past(sum_ch3))); // R10

endmodule

bind bayer_black_stats bayer_black_stats_checker #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_valid),
    .s_sof        (s_sof),
    .s_data       (s_data),
    .m_data       (m_data),
    .cfg_commit   (cfg_commit),
    .freeze_req   (freeze_req),
    .stat_running (stat_running),
    .stat_pending (stat_pending),
    .stat_frozen  (stat_frozen),
    .frame_csum   (frame_csum),
    .sum_ch0      (sum_ch0),
    .sum_ch1      (sum_ch1),
    .sum_ch2      (sum_ch2),
    .sum_ch3      (sum_ch3)
);

// File: tb/bayer_black_stats_bench.sv
module bayer_black_stats_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 10;
    localparam int ACC_W = 14;
    localparam int WATCHDOG = 50000;
    localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_valid = 0, s_sof = 0, s_eol = 0;
    logic [PIX_W-1:0] s_data = '0;
    logic m_valid, m_sof, m_eol;
    logic [PIX_W-1:0] m_data;
    logic [15:0] h_first = 0, h_limit = 0, v_before = 0, v_last = 0;
    logic [1:0] phase = 0;
    logic commit = 0, req = 0;
    logic running, pending, frozen;
    logic [7:0] csum;
    logic [ACC_W-1:0] s0, s1, s2, s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    bayer_black_stats #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_bayer_black_stats (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
        .m_valid(m_valid), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
        .roi_h_first(h_first), .roi_h_limit(h_limit),
        .roi_v_before(v_before), .roi_v_last(v_last),
        .cfa_phase(phase), .cfg_commit(commit), .freeze_req(req),
        .stat_running(running), .stat_pending(pending), .stat_frozen(frozen),
        .frame_csum(csum),
        .sum_ch0(s0), .sum_ch1(s1), .sum_ch2(s2), .sum_ch3(s3)
    );

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R11";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int x_next, y_next;
    int act_c[5], stg_c[5];
    bit m_pend;
    int m_st; // 0 idle 1 armed 2 gather 3 hold
    longint m_sum[4];
    int m_run, m_csum;
    bit m_frozen;

    always @(posedge clk) begin
        if (!rst_n) begin
            x_next = 0; y_next = 0;
            act_c = '{0, 0, 65535, 0, 0};
            stg_c = act_c;
            m_pend = 0; m_st = 0; m_sum = '{0, 0, 0, 0};
            m_run = 0; m_csum = 0; m_frozen = 0;
        end else begin
            int cx, cy, vf, ch, px;
            int eff[5];
            bit fs, inr;
            fs = s_valid && s_sof;
            cx = s_sof ? 0 : x_next;
            cy = s_sof ? 0 : y_next;
            px = int'(s_data);
            eff = (fs && m_pend) ? stg_c : act_c;
            vf = (eff[2] + 1) % 65536;
            inr = (cx >= eff[0]) && (cx < eff[1]) && (cy >= vf) && (cy <= eff[3]);
            ch = (((cy % 2) ^ (eff[4] / 2)) * 2) + ((cx % 2) ^ (eff[4] % 2));
            case (m_st)
                0: if (req) begin m_st = 1; m_frozen = 0; end
                1: if (fs) begin
                       m_st = 2;
                       m_sum = '{0, 0, 0, 0};
                       if (inr) m_sum[ch] = px;
                       m_run = px % 256;
                   end
                2: if (fs) begin
                       m_st = 3; m_frozen = 1; m_csum = m_run;
                   end else if (s_valid) begin
                       if (inr) m_sum[ch] = (m_sum[ch] + px > ACC_MAX) ? ACC_MAX : m_sum[ch] + px;
                       m_run = (m_run + px) % 256;
                   end
                default: if (!req) m_st = 0;
            endcase
            if (fs && m_pend) act_c = stg_c;
            if (commit) begin
                stg_c = '{int'(h_first), int'(h_limit), int'(v_before), int'(v_last), int'(phase)};
                m_pend = 1;
            end else if (fs) m_pend = 0;
            if (s_valid) begin
                if (s_eol) begin x_next = 0; y_next = cy + 1; end
                else begin x_next = cx + 1; y_next = cy; end
            end
        end
    end

    task automatic compare_all();
        chk(m_valid == s_valid && m_data == s_data && m_sof == s_sof && m_eol == s_eol,
            "R1", "pass-through data", m_data, s_data);
        chk(s0 == m_sum[0], cur_tag, "sum ch0", s0, m_sum[0]);
        chk(s1 == m_sum[1], cur_tag, "sum ch1", s1, m_sum[1]);
        chk(s2 == m_sum[2], cur_tag, "sum ch2", s2, m_sum[2]);
        chk(s3 == m_sum[3], cur_tag, "sum ch3", s3, m_sum[3]);
        chk(pending == m_pend, "R5", "pending", pending, m_pend);
        chk(frozen == m_frozen, "R7", "frozen", frozen, m_frozen);
        chk(running == (m_st == 2), "R7", "running", running, m_st == 2);
        chk(csum == m_csum, "R9", "checksum", csum, m_csum);
    endtask

    // inputs change 1 time unit after the edge; outputs sampled there too
    task automatic step();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic set_cfg(input int hf, input int hl, input int vb, input int vl, input int ph);
        h_first = 16'(hf); h_limit = 16'(hl); v_before = 16'(vb); v_last = 16'(vl);
        phase = 2'(ph);
        commit = 1; step(); commit = 0;
    endtask

    task automatic send_frame(input int w, input int h, input int seed,
                              input bit maxval, input int commit_at);
        int idx = 0;
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                if ((x + y + seed) % 3 == 0) begin
                    s_valid = 0; s_sof = 0; s_eol = 0; step();
                end
                s_valid = 1;
                s_data = maxval ? PIX_W'(PIX_MAX) : PIX_W'((x * 37 + y * 101 + seed * 13) % (PIX_MAX + 1));
                s_sof = (x == 0 && y == 0);
                s_eol = (x == w - 1);
                commit = (idx == commit_at);
                step();
                commit = 0;
                idx++;
            end
        end
        s_valid = 0; s_sof = 0; s_eol = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    bit finished = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        step();
        // R11: reset state
        chk(!running && !pending && !frozen, "R11", "status after reset", {running, pending, frozen}, 0);
        chk(s0 == 0 && s1 == 0 && s2 == 0 && s3 == 0 && csum == 0, "R11", "totals after reset", s0 + s1 + s2 + s3, 0);
        // R11: empty region: a round before any commit stays at zero
        req = 1; step();
        send_frame(4, 3, 7, 0, -1);
        send_frame(4, 3, 8, 0, -1);
        chk(frozen == 1 && (s0 | s1 | s2 | s3) == 0, "R11", "empty region totals", s0 | s1 | s2 | s3, 0);
        req = 0; idle(2);

        // R2 + R6: commit then request while pending
        cur_tag = "R2";
        set_cfg(1, 3, 0, 2, 0);
        req = 1; step();
        chk(pending == 1 && frozen == 0, "R6", "request accepted while pending", pending, 1);
        send_frame(5, 4, 1, 0, -1);
        send_frame(5, 4, 2, 0, -1);
        chk(frozen == 1 && running == 0, "R7", "round ended", frozen, 1);
        req = 0; idle(3);

        // R8: no request, frame ignored
        cur_tag = "R8";
        send_frame(5, 4, 3, 0, -1);
        chk(frozen == 1, "R8", "frozen held without request", frozen, 1);

        // R3 + R4: v_before 65535 means line 0, phase 3
        cur_tag = "R3";
        set_cfg(0, 6, 65535, 0, 3);
        req = 1; step();
        send_frame(6, 3, 4, 0, -1);
        send_frame(6, 3, 5, 0, -1);
        // R8: request held high, further frames ignored
        cur_tag = "R8";
        send_frame(6, 3, 6, 0, -1);
        chk(frozen == 1, "R8", "still frozen while request high", frozen, 1);
        req = 0; idle(2);

        // R4 + R5: commit in the middle of a gathered frame
        cur_tag = "R4";
        set_cfg(0, 8, 65535, 5, 1);
        req = 1; step();
        send_frame(8, 6, 9, 0, -1);
        set_cfg(2, 5, 1, 3, 2);
        send_frame(8, 6, 10, 0, -1);
        req = 0; idle(2);
        cur_tag = "R5";
        h_first = 0; h_limit = 8; v_before = 65535; v_last = 5; phase = 1;
        req = 1; step();
        send_frame(7, 5, 11, 0, 6);
        chk(pending == 1, "R5", "mid-frame commit still pending", pending, 1);
        send_frame(7, 5, 12, 0, -1);
        chk(pending == 0, "R5", "commit applied at frame start", pending, 0);
        req = 0; idle(2);
        req = 1; step();
        send_frame(7, 5, 13, 0, -1);
        send_frame(7, 5, 14, 0, -1);
        req = 0; idle(2);

        // R10: saturation
        cur_tag = "R10";
        set_cfg(0, 10, 65535, 7, 2);
        req = 1; step();
        send_frame(10, 8, 15, 1, -1);
        send_frame(10, 8, 16, 1, -1);
        chk(s0 == ACC_MAX && s3 == ACC_MAX, "R10", "saturated total", s0, ACC_MAX);
        // R9: checksum of the max-value frame: 80 * 1023 mod 256
        chk(csum == (80 * PIX_MAX) % 256, "R9", "checksum value", csum, (80 * PIX_MAX) % 256);
        req = 0; idle(4);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule